// File: doc/BRIEF.md
# I2C Control Register Access Controller

This block owns the 16-bit control word of an I2C controller and decides, cycle by cycle, which parts of a software write take effect. A write is filtered by the bus-busy indication from the bus engine and by the module's internal reset bit. Hardware events from the bus engine then act on the result. An address match, a lost arbitration or a general call each drop the master bit, and a received R/W bit sets the transfer direction while the block is in slave mode.

The stored bits leave the block as registered control lines for the bus engine. The same bits are also available as a zero-padded read word. The bit-level bus state machine, clock stretching and the data shifter sit outside this block.

Top module: `i2c_ctrl_reg`

## Requirements
- R1: A synchronous reset (rst = 1 at a clock edge) clears the whole control word to 0000h after that edge.
- R2: rd_data always shows the stored bits at fixed positions: bit 0 enable, bit 1 master, bit 2 direction (1 = master reading), bit 3 START, bit 4 STOP, bit 5 acknowledge control, bit 6 soft reset. Bits 15:7 read 0, and writes to them have no effect.
- R3: START and STOP are held at 0 whenever the enable bit or the master bit is 0.
- R4: A write that sets both START and STOP leaves both of them 0.
- R5: The soft reset bit is held at 0 whenever the enable bit is 0.
- R6: While bus_busy is 1, writes to the master bit and to the direction bit are ignored.
- R7: While bus_busy is 1, writes to the enable bit are ignored unless the stored soft reset bit is 1, in which case the enable bit takes the written value.
- R8: While the stored soft reset bit is 1, writes to the acknowledge-control bit are ignored.
- R9: An address match, an arbitration loss or a general call clears the master bit at the next edge, and this clear wins over a software write that sets the bit in the same cycle.
- R10: While the stored master bit is 0, software writes to the direction bit are ignored. A valid received R/W bit loads the direction bit whenever the master bit is 0 after that edge.
- R11: With bus_busy at 0 and no reset bit set, a write updates every writable bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| bus_busy | input | 1 | Bus engine reports a transfer in progress |
| ev_addr_match | input | 1 | Pulse: own slave address matched |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_gen_call | input | 1 | Pulse: general call received |
| ev_rw_valid | input | 1 | Pulse: received R/W bit is valid |
| ev_rw_bit | input | 1 | Received R/W bit (1 = read) |
| rd_data | output | 16 | Read-back of the control word |
| ctl_en | output | 1 | Enable bit |
| ctl_master | output | 1 | Master mode bit |
| ctl_read | output | 1 | Direction bit (1 = master reading) |
| ctl_start | output | 1 | START request |
| ctl_stop | output | 1 | STOP request |
| ctl_ack | output | 1 | Acknowledge control bit |
| ctl_srst | output | 1 | Soft reset bit |

## Verification
The bench targets the cases where permission rules overlap. One case is a busy write while soft reset is set: enable must follow the write, master must not, and acknowledge control must hold. A design that gates enable by busy alone would keep the module enabled in that case. Another case is an address match arriving in the same cycle as a write that sets master and START. A design that lets software win there would keep master set and issue a START. A write that sets both START and STOP is also checked, since a wrong design would let one of them through. Direction writes in slave mode are checked as well, since a wrong design would let software overwrite the received R/W bit.

// File: rtl/i2c_cr_pkg.sv
package i2c_cr_pkg;
  localparam int CR_W = 7;

  typedef struct packed {
    logic srst;
    logic ack;
    logic stop;
    logic start;
    logic rd;
    logic mst;
    logic en;
  } cr_t;
endpackage

// File: rtl/i2c_cr_wgate.sv
module i2c_cr_wgate
  import i2c_cr_pkg::*;
(
  input  cr_t  cur,
  input  logic wr_en,
  input  cr_t  wdat,
  input  logic bus_busy,
  output cr_t  sw_next
);
  logic en_ok, mst_ok, rd_ok, ack_ok;

  always_comb begin
    en_ok  = wr_en && (!bus_busy || cur.srst);
    mst_ok = wr_en && !bus_busy;
    rd_ok  = wr_en && !bus_busy && cur.mst;
    ack_ok = wr_en && !cur.srst;

    sw_next = cur;
    if (en_ok)  sw_next.en  = wdat.en;
    if (mst_ok) sw_next.mst = wdat.mst;
    if (rd_ok)  sw_next.rd  = wdat.rd;
    if (ack_ok) sw_next.ack = wdat.ack;
    if (wr_en) begin
      sw_next.srst = wdat.srst;
      if (wdat.start && wdat.stop) begin
        sw_next.start = 1'b0;
        sw_next.stop  = 1'b0;
      end else begin
        sw_next.start = wdat.start;
        sw_next.stop  = wdat.stop;
      end
    end
  end
endmodule

// File: rtl/i2c_cr_hwmerge.sv
module i2c_cr_hwmerge
  import i2c_cr_pkg::*;
(
  input  cr_t  sw_next,
  input  logic ev_addr_match,
  input  logic ev_arb_lost,
  input  logic ev_gen_call,
  input  logic ev_rw_valid,
  input  logic ev_rw_bit,
  output cr_t  cr_next
);
  logic hw_clr;

  always_comb begin
    hw_clr  = ev_addr_match || ev_arb_lost || ev_gen_call;
    cr_next = sw_next;
    if (hw_clr) cr_next.mst = 1'b0;
    if (ev_rw_valid && !cr_next.mst) cr_next.rd = ev_rw_bit;
    if (!cr_next.en) cr_next.srst = 1'b0;
    if (!(cr_next.en && cr_next.mst)) begin
      cr_next.start = 1'b0;
      cr_next.stop  = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
  import i2c_cr_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bus_busy,
  input  logic             ev_addr_match,
  input  logic             ev_arb_lost,
  input  logic             ev_gen_call,
  input  logic             ev_rw_valid,
  input  logic             ev_rw_bit,
  output logic [REG_W-1:0] rd_data,
  output logic             ctl_en,
  output logic             ctl_master,
  output logic             ctl_read,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_ack,
  output logic             ctl_srst
);
  localparam int PAD_W = REG_W - CR_W;

  cr_t cr_q, sw_next, cr_next, wdat;

  assign wdat = cr_t'(wr_data[CR_W-1:0]);

  i2c_cr_wgate u_wgate (
    .cur      (cr_q),
    .wr_en    (wr_en),
    .wdat     (wdat),
    .bus_busy (bus_busy),
    .sw_next  (sw_next)
  );

  i2c_cr_hwmerge u_hwmerge (
    .sw_next       (sw_next),
    .ev_addr_match (ev_addr_match),
    .ev_arb_lost   (ev_arb_lost),
    .ev_gen_call   (ev_gen_call),
    .ev_rw_valid   (ev_rw_valid),
    .ev_rw_bit     (ev_rw_bit),
    .cr_next       (cr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else     cr_q <= cr_next;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, cr_q};
    end else begin : g_nopad
      assign rd_data = cr_q[REG_W-1:0];
    end
  endgenerate

  assign ctl_en     = cr_q.en;
  assign ctl_master = cr_q.mst;
  assign ctl_read   = cr_q.rd;
  assign ctl_start  = cr_q.start;
  assign ctl_stop   = cr_q.stop;
  assign ctl_ack    = cr_q.ack;
  assign ctl_srst   = cr_q.srst;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  assert_start_needs_master_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_start || ctl_stop) |-> (ctl_en && ctl_master));

  assert_start_stop_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(ctl_start && ctl_stop));

  assert_srst_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    ctl_srst |-> ctl_en);

  assert_busy_no_master_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_busy && !ctl_master) |=> !ctl_master);

  assert_busy_en_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_busy && !ctl_srst) |=> $stable(ctl_en));

  assert_ack_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_srst) |=> $stable(ctl_ack));

  assert_hw_clears_master_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_match || ev_arb_lost || ev_gen_call) |=> !ctl_master);

  assert_rw_loads_dir_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_rw_valid && ev_addr_match) |=> (ctl_read == $past(ev_rw_bit)));
endmodule

// File: tb/i2c_ctrl_reg_bench.sv
module i2c_ctrl_reg_bench;
  logic clk = 1'b0;
  logic rst;
  logic wr_en, bus_busy, am, al, gc, rwv, rwb;
  logic [15:0] wr_data, rd_data;
  logic c_en, c_mst, c_rd, c_st, c_sp, c_ack, c_srst;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_ctrl_reg u_i2c_ctrl_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bus_busy(bus_busy),
    .ev_addr_match(am), .ev_arb_lost(al), .ev_gen_call(gc),
    .ev_rw_valid(rwv), .ev_rw_bit(rwb), .rd_data(rd_data),
    .ctl_en(c_en), .ctl_master(c_mst), .ctl_read(c_rd), .ctl_start(c_st),
    .ctl_stop(c_sp), .ctl_ack(c_ack), .ctl_srst(c_srst)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic        busy, am, al, gc, rwv, rwb;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003}, // R11
    '{1'b1, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007}, // R11
    '{1'b1, 16'h001F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007}, // R4
    '{1'b1, 16'h000F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000F}, // R11
    '{1'b1, 16'h0017, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0017}, // R11
    '{1'b1, 16'h0023, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0027}, // R6
    '{1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007}, // R7
    '{1'b1, 16'h0047, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0047}, // R11
    '{1'b1, 16'h0066, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0006}, // R7 R8 R5
    '{1'b1, 16'h000B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000B}, // R11
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001}, // R9 R3
    '{1'b1, 16'h0007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003}, // R10
    '{1'b1, 16'h000B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0005}, // R9 R10
    '{1'b1, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007}, // R10
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0005}, // R9
    '{1'b1, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0024}, // R10
    '{1'b1, 16'h0050, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0004}, // R3 R5
    '{1'b1, 16'hFF81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0005}, // R2
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001}  // R10
  };

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; bus_busy = 0; am = 0; al = 0; gc = 0; rwv = 0; rwb = 0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    wr_en = v.wr; wr_data = v.data; bus_busy = v.busy;
    am = v.am; al = v.al; gc = v.gc; rwv = v.rwv; rwb = v.rwb;
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset state", rd_data, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("vec%0d", i), rd_data, VEC[i].exp);
    end

    // R2 control lines match the read word
    check("R2 lines", {9'd0, c_srst, c_ack, c_sp, c_st, c_rd, c_mst, c_en}, rd_data);

    // R9 clear wins over simultaneous set by software, start forced low (R3)
    apply('{1'b1, 16'h000B, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0});
    check("R9 gencall priority", rd_data, 16'h0001);

    // R1 reset from a non-zero word
    apply('{1'b1, 16'h0023, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0});
    check("R11 pre-reset", rd_data, 16'h0023);
    @(negedge clk); rst = 1;
    @(posedge clk); #2; rst = 0;
    check("R1 reset clears", rd_data, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule